// File: doc/BRIEF.md
# SPI Controller with Programmable First-Word Delay

This block is a single-channel SPI transfer engine for the controller side of the link. Software programs a small control register and writes a word into the transmit holding register. The engine then shifts that word out most significant bit first on `mosi` and collects a word from `miso` at the same time. The clock uses mode 0: `sclk` idles low, data changes after the falling edge and is sampled on the rising edge. `sclk` runs at the system clock divided by the even parameter `CLK_DIV`.

The first word after each channel enable can be held back by 4, 8, 16 or 32 SPI clock periods. During that wait the clock stays idle and chip-select stays released. A three-pin option removes chip-select from the link entirely. The block powers up in peripheral mode. In that mode it generates nothing until software clears the mode bit.

The bus map has three words. Address 0 is the control register. Address 1 accepts transmit data on write and returns status on read. Address 2 returns the received word.

Top module: `spi_start_delay_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x0000_0004, address 1 reads 0, `busy` and `rx_valid` are low, `cs_n` is high and `sclk` is low.
- R2: In the control register, bits 6:4 hold the delay code, bit 2 selects peripheral mode (1) or controller mode (0), bit 1 selects three-pin mode and bit 0 is the single-channel flag. Every other bit reads 0 and ignores writes.
- R3: A write to address 1 starts a transfer only when `chan_en` is 1, bit 2 is 0 and `busy` is low. Any other such write is ignored: no `busy`, no clock, and no change to the word in flight.
- R4: The wait D, in system clocks, is the number of SPI clocks times `CLK_DIV`. Delay codes 1, 2, 3 and 4 give 4, 8, 16 and 32 SPI clocks. Codes 0 and 5 to 7 give no wait.
- R5: While the wait runs, `sclk` stays low and `cs_n` stays high.
- R6: The wait applies only when bit 0 is 1. With bit 0 clear, the first word starts at once.
- R7: The wait applies only to the first word accepted after `chan_en` rises. Later words start at once. Dropping and raising `chan_en` re-arms the wait.
- R8: The word goes out MSB first, one bit per SPI clock. `mosi` is stable while `sclk` is high. The received word is the `miso` values sampled on the rising edges, MSB first.
- R9: Counted from the accepting edge, `cs_n` falls after D cycles. The first `sclk` rise comes CLK_DIV/2 cycles after that. `busy` stays high for D + WORD_W*CLK_DIV + CLK_DIV/2 cycles, so `cs_n` is released half an SPI clock after the last falling edge.
- R10: With bit 1 set, `cs_n` never goes low.
- R11: When `busy` falls, `rx_valid` rises and the received word is held at address 2. Address 1 reads {rx_valid, busy} in bits 1:0. A read of address 2 clears `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| busy | output | 1 | Transfer in progress |
| rx_valid | output | 1 | Received word waiting |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Active-low chip-select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong delay count or a stale first-word flag appears at the ports as soon as the next word is written. The chip-select fall and the first clock rise land on the wrong cycle, and the length of `busy` is off by a whole number of SPI clocks. A slipped bit counter or phase counter changes the `busy` length and corrupts both the captured `mosi` word and the word at address 2 within one transfer. A wrong pin-mode or mode bit decode shows on the first transfer, either as a chip-select pulse in three-pin mode or as a clock that runs in peripheral mode.

// File: rtl/spi_sd_pkg.sv
package spi_sd_pkg;

    typedef struct packed {
        logic [2:0] dly_code;
        logic       periph;
        logic       three_pin;
        logic       single;
    } cfg_t;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_RX   = 2'd2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DELAY,
        SQ_LEAD,
        SQ_HIGH,
        SQ_LOW,
        SQ_TRAIL
    } seq_state_e;

    function automatic int unsigned dly_spi_clks(input logic [2:0] code);
        case (code)
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 32;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/spi_sd_cfg_reg.sv
module spi_sd_cfg_reg
    import spi_sd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [6:0] wdata,
    output cfg_t       cfg,
    output logic [31:0] rdata
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.dly_code  = wdata[6:4];
            cfg_d.periph    = wdata[2];
            cfg_d.three_pin = wdata[1];
            cfg_d.single    = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{dly_code: 3'd0, periph: 1'b1, three_pin: 1'b0, single: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg   = cfg_q;
    assign rdata = {24'd0, 1'b0, cfg_q.dly_code, 1'b0,
                    cfg_q.periph, cfg_q.three_pin, cfg_q.single};

endmodule

// File: rtl/spi_sd_seq.sv
module spi_sd_seq
    import spi_sd_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int CLK_DIV = 4,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] dly_cyc,
    output logic             sclk,
    output logic             frame,
    output logic             busy,
    output logic             sample_en,
    output logic             shift_en,
    output logic             done
);

    localparam int HALF  = CLK_DIV / 2;
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(HALF - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bitn;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d         = q;
        sample_en = 1'b0;
        shift_en  = 1'b0;
        done      = 1'b0;
        unique case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    d.bitn = '0;
                    if (dly_cyc != '0) begin
                        d.st  = SQ_DELAY;
                        d.cnt = dly_cyc - 1'b1;
                    end else begin
                        d.st  = SQ_LEAD;
                        d.cnt = HALF_M1;
                    end
                end
            end
            SQ_DELAY: begin
                if (q.cnt == '0) begin
                    d.st  = SQ_LEAD;
                    d.cnt = HALF_M1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_LEAD: begin
                if (q.cnt == '0) begin
                    d.st      = SQ_HIGH;
                    d.cnt     = HALF_M1;
                    sample_en = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_HIGH: begin
                if (q.cnt == '0) begin
                    d.cnt = HALF_M1;
                    if (q.bitn == LAST_BIT) begin
                        d.st = SQ_TRAIL;
                    end else begin
                        d.st     = SQ_LOW;
                        d.bitn   = q.bitn + 1'b1;
                        shift_en = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_LOW: begin
                if (q.cnt == '0) begin
                    d.st      = SQ_HIGH;
                    d.cnt     = HALF_M1;
                    sample_en = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_TRAIL: begin
                if (q.cnt == '0) begin
                    d.st = SQ_IDLE;
                    done = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, cnt: '0, bitn: '0};
        end else begin
            q <= d;
        end
    end

    assign sclk  = (q.st == SQ_HIGH);
    assign busy  = (q.st != SQ_IDLE);
    assign frame = (q.st == SQ_LEAD) || (q.st == SQ_HIGH) ||
                   (q.st == SQ_LOW)  || (q.st == SQ_TRAIL);

endmodule

// File: rtl/spi_sd_shifter.sv
module spi_sd_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.tx = load_word;
        end else if (shift_en) begin
            d.tx = {q.tx[WORD_W-2:0], 1'b0};
        end
        if (sample_en) begin
            d.rx = {q.rx[WORD_W-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mosi    = q.tx[WORD_W-1];
    assign rx_word = q.rx;

endmodule

// File: rtl/spi_start_delay_ctrl.sv
module spi_start_delay_ctrl
    import spi_sd_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chan_en,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        busy,
    output logic        rx_valid,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);

    localparam int MAX_DLY = 32 * CLK_DIV;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    cfg_t              cfg;
    logic [31:0]       cfg_rdata;
    logic              three_pin_mode;
    logic              periph_mode;
    logic              accept;
    logic [CNT_W-1:0]  dly_cyc;
    logic              frame, sample_en, shift_en, done;
    logic [WORD_W-1:0] rx_word;

    typedef struct packed {
        logic              first;
        logic              rx_valid;
        logic [WORD_W-1:0] rx_hold;
    } top_t;

    top_t d, q;

    spi_sd_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we && (bus_addr == ADDR_CFG)),
        .wdata (bus_wdata[6:0]),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    assign three_pin_mode = cfg.three_pin;
    assign periph_mode    = cfg.periph;

    assign accept = bus_we && (bus_addr == ADDR_DATA) && chan_en && !periph_mode && !busy;

    assign dly_cyc = (q.first && cfg.single)
                   ? CNT_W'(dly_spi_clks(cfg.dly_code) * CLK_DIV)
                   : '0;

    spi_sd_seq #(
        .WORD_W  (WORD_W),
        .CLK_DIV (CLK_DIV),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .dly_cyc   (dly_cyc),
        .sclk      (sclk),
        .frame     (frame),
        .busy      (busy),
        .sample_en (sample_en),
        .shift_en  (shift_en),
        .done      (done)
    );

    spi_sd_shifter #(
        .WORD_W (WORD_W)
    ) u_sh (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (bus_wdata[WORD_W-1:0]),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    always_comb begin
        d = q;
        if (!chan_en) begin
            d.first = 1'b1;
        end else if (accept) begin
            d.first = 1'b0;
        end
        if (done) begin
            d.rx_valid = 1'b1;
            d.rx_hold  = rx_word;
        end else if (bus_re && (bus_addr == ADDR_RX)) begin
            d.rx_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{first: 1'b1, rx_valid: 1'b0, rx_hold: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CFG:  bus_rdata = cfg_rdata;
            ADDR_DATA: bus_rdata = {30'd0, q.rx_valid, busy};
            ADDR_RX:   bus_rdata = 32'(q.rx_hold);
            default:   bus_rdata = 32'd0;
        endcase
    end

    assign rx_valid = q.rx_valid;
    assign cs_n     = !(frame && !three_pin_mode);

endmodule

// File: rtl/spi_sd_chk.sv
module spi_sd_chk (
    input logic clk,
    input logic rst_n,
    input logic chan_en,
    input logic periph,
    input logic three_pin,
    input logic busy,
    input logic rx_valid,
    input logic sclk,
    input logic cs_n,
    input logic mosi
);

    // R1
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R3
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(chan_en) && !$past(periph)));

    // R5
    quiet_before_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cs_n && !three_pin) |-> !sclk);

    // R8
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R10
    three_pin_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        three_pin |-> cs_n);

    // R11
    valid_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $fell(busy));

endmodule

bind spi_start_delay_ctrl spi_sd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .periph    (periph_mode),
    .three_pin (three_pin_mode),
    .busy      (busy),
    .rx_valid  (rx_valid),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi)
);

// File: tb/tb_spi_start_delay_ctrl.sv
module tb_spi_start_delay_ctrl;

    localparam int W      = 8;
    localparam int DIV    = 4;
    localparam int HALF   = DIV / 2;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        busy, rx_valid, sclk, cs_n, mosi;
    logic        miso = 1'b0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [W-1:0] slv_sh;
    logic [W-1:0] cap;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_start_delay_ctrl #(.WORD_W(W), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .rx_valid(rx_valid), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always @(negedge sclk) begin
        slv_sh = {slv_sh[W-2:0], 1'b0};
        miso   = slv_sh[W-1];
    end

    always @(posedge sclk) cap = {cap[W-2:0], mosi};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_delay(input logic [2:0] code, input bit single, input bit first);
        int n;
        case (code)
            3'd1: n = 4;
            3'd2: n = 8;
            3'd3: n = 16;
            3'd4: n = 32;
            default: n = 0;
        endcase
        return (first && single) ? n * DIV : 0;
    endfunction

    // Ends at the negedge after the write edge with strobes cleared.
    task automatic bus_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic reenable();
        @(negedge clk); chan_en = 1'b0;
        @(negedge clk); chan_en = 1'b1;
    endtask

    task automatic run_xfer(input logic [W-1:0] txw, input logic [W-1:0] slvw,
                            input int exp_d, input bit pin3, input bit poke);
        int k, cs_first, rise_first;
        logic [31:0] v;
        slv_sh = slvw; miso = slvw[W-1]; cap = '0;
        bus_write(2'd1, 32'(txw));
        k = 0; cs_first = -1; rise_first = -1;
        while (busy && k < 5000) begin
            if (!cs_n && cs_first < 0) cs_first = k;
            if (sclk && rise_first < 0) rise_first = k;
            if (poke && k == 2) begin bus_addr = 2'd1; bus_wdata = 32'(~txw); bus_we = 1'b1; end
            if (poke && k == 3) bus_we = 1'b0;
            @(negedge clk);
            k++;
        end
        if (pin3) chk(cs_first == -1, "R10 cs_n stays high", cs_first, -1);
        else      chk(cs_first == exp_d, "R4/R9 cs_n fall cycle", cs_first, exp_d);
        chk(rise_first == exp_d + HALF, "R5/R9 first sclk rise", rise_first, exp_d + HALF);
        chk(k == exp_d + W*DIV + HALF, "R9 busy length", k, exp_d + W*DIV + HALF);
        chk(rx_valid == 1'b1, "R11 rx_valid set", rx_valid, 1);
        chk(cap == txw, "R8/R3 mosi word", cap, txw);
        bus_read(2'd2, v);
        chk(v == 32'(slvw), "R8/R11 rx word", v, slvw);
        bus_read(2'd1, v);
        chk(v == 32'd0, "R11 status after read", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int idle_busy;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, v); chk(v == 32'h4, "R1 cfg reset", v, 4);
        bus_read(2'd1, v); chk(v == 32'h0, "R1 status reset", v, 0);
        chk(cs_n && !sclk && !busy && !rx_valid, "R1 pins idle", {cs_n, sclk, busy, rx_valid}, 4'b1000);

        // R2 field layout and reserved bits
        bus_write(2'd0, 32'hFFFF_FFFF);
        bus_read(2'd0, v); chk(v == 32'h77, "R2 writable bits", v, 32'h77);
        bus_write(2'd0, 32'h0);
        bus_read(2'd0, v); chk(v == 32'h0, "R2 clear", v, 0);

        // R3 ignored writes: peripheral mode, then channel disabled
        bus_write(2'd0, 32'h4);
        chan_en = 1'b1;
        bus_write(2'd1, 32'hA5);
        idle_busy = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy || sclk) idle_busy++;
            @(negedge clk);
        end
        chk(idle_busy == 0, "R3 peripheral mode ignores tx", idle_busy, 0);
        bus_write(2'd0, 32'h0);
        chan_en = 1'b0;
        bus_write(2'd1, 32'hA5);
        idle_busy = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy || sclk) idle_busy++;
            @(negedge clk);
        end
        chk(idle_busy == 0, "R3 disabled channel ignores tx", idle_busy, 0);

        // R4 every delay code, single channel, four-pin
        for (int c = 0; c < 8; c++) begin
            bus_write(2'd0, {25'd0, 3'(c), 4'b0001});
            reenable();
            run_xfer(8'h3C ^ 8'(c), 8'hC3 + 8'(c), exp_delay(3'(c), 1'b1, 1'b1), 1'b0, 1'b0);
        end

        // R7 second word without re-enable gets no delay
        bus_write(2'd0, 32'h41);
        reenable();
        run_xfer(8'h81, 8'h18, exp_delay(3'd4, 1'b1, 1'b1), 1'b0, 1'b0);
        run_xfer(8'h7E, 8'hE7, exp_delay(3'd4, 1'b1, 1'b0), 1'b0, 1'b0);

        // R6 single-channel flag clear: no delay
        bus_write(2'd0, 32'h40);
        reenable();
        run_xfer(8'h55, 8'hAA, exp_delay(3'd4, 1'b0, 1'b1), 1'b0, 1'b0);

        // R10 three-pin with delay
        bus_write(2'd0, 32'h23);
        reenable();
        run_xfer(8'hF0, 8'h0F, exp_delay(3'd2, 1'b1, 1'b1), 1'b1, 1'b0);

        // R3 write while busy is dropped
        bus_write(2'd0, 32'h0);
        reenable();
        run_xfer(8'h96, 8'h69, 0, 1'b0, 1'b1);

        // R11 rx_valid held until read
        run_xfer(8'h01, 8'h80, 0, 1'b0, 1'b0);
        bus_write(2'd1, 32'h02);
        repeat (W*DIV + HALF + 2) @(negedge clk);
        chk(rx_valid == 1'b1, "R11 rx_valid held", rx_valid, 1);
        bus_read(2'd2, v);
        bus_read(2'd1, v); chk(v == 32'd0, "R11 cleared by read", v, 0);

        // Random mix of modes, codes and re-enables
        for (int i = 0; i < 24; i++) begin
            logic [2:0] code;
            bit single, pin3, fresh;
            code   = 3'($urandom_range(0, 7));
            single = 1'($urandom_range(0, 1));
            pin3   = 1'($urandom_range(0, 1));
            fresh  = (i == 0) ? 1'b1 : 1'($urandom_range(0, 1));
            bus_write(2'd0, {25'd0, code, 1'b0, 1'b0, pin3, single});
            if (fresh) reenable();
            run_xfer(W'($urandom), W'($urandom) , exp_delay(code, single, fresh), pin3, 1'b0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule